// File: doc/BRIEF.md
# Blocking Line Directory for an Inclusive Shared Cache

This block is the coherence directory that sits beside a shared, inclusive second-level cache. It tracks every line separately: a state, a bit-vector of private caches that may hold a read-only copy, and the index of the single private cache that holds the line exclusively. Private caches send read, instruction-fetch, write and upgrade requests on one request channel. Unblock and writeback notices arrive on a separate message channel, and memory fetches use a simple request/return handshake.

For each request the directory does exactly one thing. It serves the data itself, forwards the request to the owning private cache, or starts a memory fetch. When it grants exclusive permission to a line that has readers, it also sends invalidations to all of those readers in the same cycle and tells the requester how many acknowledgements to collect. A transaction that hands over ownership leaves the line in a blocking state. Further requests for that line are held on the request channel (`req_ready` low) until the unblock message arrives. A forwarded read must also wait for the writeback from the previous owner, and the two messages may arrive in either order.

Top module: `coherence_dir`

## Requirements
- R1: After reset every line is absent. Any request to an absent line is accepted and raises `mem_req_valid` with that line on the cycle after acceptance. In that cycle no response and no forward are issued.
- R2: Each accepted request (`req_valid && req_ready` at a clock edge) produces exactly one of response, forward or fetch on the next cycle. `req_ready` is low while the addressed line is blocking, while `mem_resp_valid` is high, or while a message addresses the same line. A held request is acted on once it is accepted.
- R3: A fetch for a read (kind 0) with no competing request is answered with exclusive data (response kind 1) and zero acknowledgements. So is a fetch for a write (kind 2) or upgrade (kind 3). The response appears one cycle after `mem_resp_valid`, addressed to the original requester.
- R4: A fetch for an instruction fetch (kind 1) is answered with shared data (response kind 0). So is a read fetch during which a different core requested the same line. The line then becomes shared, with the requester as its only sharer.
- R5: On a shared line, a read or instruction fetch is answered with shared data (kind 0), and the requester is added to the sharers.
- R6: On a shared line, a write or upgrade sends invalidations to every sharer except the requester, in the same cycle as the response. `rsp_acks` equals the number of cores invalidated. An upgrade from a current sharer gets an acknowledgement-only response (kind 2). Any other exclusive request gets exclusive data (kind 1).
- R7: On a line held only by the shared cache with exclusive permission, a read, write or upgrade is answered with exclusive data (kind 1), with no forward and no fetch. An instruction fetch is answered with shared data (kind 0).
- R8: After an exclusive grant, the line holds all requests until an unblock (message kind 0) from that requester arrives. The line is then owned exclusively by that requester.
- R9: On a line owned by a private cache, every request is forwarded to the owner and never answered locally. Reads and instruction fetches use forward kind 0. Writes and upgrades use forward kind 1 and make the requester the next owner after its unblock.
- R10: A forwarded read finishes only after both an unblock from the requester and a writeback (message kind 1) from the old owner have arrived, in either order. The line then becomes shared with exactly those two cores as sharers.
- R11: A writeback from the owner of a privately owned line returns the line to exclusive ownership by the shared cache.
- R12: A message from a core the line is not waiting on, or a message to a line in a state that expects no message, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 read, 1 instruction fetch, 2 write, 3 upgrade |
| req_core | input | $clog2(NUM_CORES) | Requesting private cache |
| req_line | input | $clog2(NUM_LINES) | Addressed line |
| msg_valid | input | 1 | Message present (always taken) |
| msg_kind | input | 1 | 0 unblock, 1 writeback |
| msg_core | input | $clog2(NUM_CORES) | Sending private cache |
| msg_line | input | $clog2(NUM_LINES) | Addressed line |
| mem_req_valid | output | 1 | Memory fetch request pulse |
| mem_req_line | output | $clog2(NUM_LINES) | Line to fetch |
| mem_resp_valid | input | 1 | Memory data returned |
| mem_resp_line | input | $clog2(NUM_LINES) | Line returned |
| rsp_valid | output | 1 | Response to a private cache |
| rsp_kind | output | 2 | 0 shared data, 1 exclusive data, 2 acknowledgements only |
| rsp_core | output | $clog2(NUM_CORES) | Destination core |
| rsp_line | output | $clog2(NUM_LINES) | Line |
| rsp_acks | output | $clog2(NUM_CORES+1) | Acknowledgements to expect |
| fwd_valid | output | 1 | Forward to the owner |
| fwd_kind | output | 1 | 0 read forward, 1 write forward |
| fwd_core | output | $clog2(NUM_CORES) | Owner receiving the forward |
| fwd_requester | output | $clog2(NUM_CORES) | Core to be served by the owner |
| fwd_line | output | $clog2(NUM_LINES) | Line |
| inv_valid | output | 1 | Invalidations issued |
| inv_mask | output | NUM_CORES | Cores to invalidate |
| inv_line | output | $clog2(NUM_LINES) | Line |

## Verification
All directory outputs are registered. The action for an accepted request shows one cycle after the edge that accepted it, and a response to a memory return shows one cycle after the edge that saw `mem_resp_valid`. The bench drives every input on a falling edge and reads the outputs on the next falling edge, which falls exactly inside that one-cycle window. For held requests it reads `req_ready` 1 ns after driving, then checks on the next falling edge that no response, forward or fetch appeared. A sweep over every non-empty sharer set and every writing core checks the invalidation mask, the acknowledgement count and the response kind against values the bench computes itself.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    typedef enum logic [3:0] {
        LN_ABSENT,
        LN_SHARED,
        LN_HOME_EXCL,
        LN_PRIV_EXCL,
        LN_FETCH,
        LN_WAIT_UNBLK,
        LN_WAIT_BOTH,
        LN_WAIT_WB,
        LN_WAIT_UNBLK_S
    } line_state_e;

    typedef enum logic [1:0] {
        RQ_READ    = 2'd0,
        RQ_IFETCH  = 2'd1,
        RQ_WRITE   = 2'd2,
        RQ_UPGRADE = 2'd3
    } req_kind_e;

    typedef enum logic {
        MS_UNBLOCK   = 1'b0,
        MS_WRITEBACK = 1'b1
    } msg_kind_e;

    typedef enum logic [1:0] {
        RS_DATA_SHARED = 2'd0,
        RS_DATA_EXCL   = 2'd1,
        RS_ACKS_ONLY   = 2'd2
    } rsp_kind_e;

    typedef enum logic {
        FW_READ  = 1'b0,
        FW_WRITE = 1'b1
    } fwd_kind_e;

    // Lines in these states accept new requests.
    function automatic logic accepts_req(input line_state_e s);
        return (s == LN_ABSENT) || (s == LN_SHARED) ||
               (s == LN_HOME_EXCL) || (s == LN_PRIV_EXCL);
    endfunction

    function automatic logic wants_excl(input req_kind_e k);
        return (k == RQ_WRITE) || (k == RQ_UPGRADE);
    endfunction

    function automatic int unsigned ones64(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/cdir_line_fsm.sv
module cdir_line_fsm
    import cdir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CW = $clog2(NUM_CORES),
    localparam int AW = $clog2(NUM_CORES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_req,
    input  logic                 ev_msg,
    input  logic                 ev_mem,
    input  logic                 snoop,
    input  req_kind_e            in_req_kind,
    input  logic [CW-1:0]        in_req_core,
    input  msg_kind_e            in_msg_kind,
    input  logic [CW-1:0]        in_msg_core,
    output logic                 is_idle,
    output logic                 act_rsp,
    output rsp_kind_e            act_rsp_kind,
    output logic [CW-1:0]        act_rsp_core,
    output logic [AW-1:0]        act_acks,
    output logic                 act_fwd,
    output fwd_kind_e            act_fwd_kind,
    output logic [CW-1:0]        act_fwd_tgt,
    output logic                 act_inv,
    output logic [NUM_CORES-1:0] act_inv_mask,
    output logic                 act_mem
);

    line_state_e          st_q, st_d;
    logic [NUM_CORES-1:0] shr_q, shr_d;
    logic [CW-1:0]        own_q, own_d;
    logic [CW-1:0]        pend_q, pend_d;
    req_kind_e            pkind_q, pkind_d;
    logic                 cont_q, cont_d;

    logic [NUM_CORES-1:0] req_bit;
    logic [NUM_CORES-1:0] others;
    logic                 rival;
    logic                 unblk_ok;
    logic                 wb_ok;
    logic [NUM_CORES-1:0] pair_bits;

    assign req_bit   = NUM_CORES'(1) << in_req_core;
    assign others    = shr_q & ~req_bit;
    assign rival     = snoop && (in_req_core != pend_q);
    assign unblk_ok  = ev_msg && (in_msg_kind == MS_UNBLOCK) && (in_msg_core == pend_q);
    assign wb_ok     = ev_msg && (in_msg_kind == MS_WRITEBACK) && (in_msg_core == own_q);
    assign pair_bits = (NUM_CORES'(1) << own_q) | (NUM_CORES'(1) << pend_q);
    assign is_idle   = accepts_req(st_q);

    always_comb begin
        st_d         = st_q;
        shr_d        = shr_q;
        own_d        = own_q;
        pend_d       = pend_q;
        pkind_d      = pkind_q;
        cont_d       = cont_q;
        act_rsp      = 1'b0;
        act_rsp_kind = RS_DATA_SHARED;
        act_rsp_core = in_req_core;
        act_acks     = '0;
        act_fwd      = 1'b0;
        act_fwd_kind = FW_READ;
        act_fwd_tgt  = own_q;
        act_inv      = 1'b0;
        act_inv_mask = '0;
        act_mem      = 1'b0;
        unique case (st_q)
            LN_ABSENT: begin
                if (ev_req) begin
                    act_mem = 1'b1;
                    pend_d  = in_req_core;
                    pkind_d = in_req_kind;
                    cont_d  = 1'b0;
                    st_d    = LN_FETCH;
                end
            end
            LN_FETCH: begin
                if (rival) cont_d = 1'b1;
                if (ev_mem) begin
                    act_rsp      = 1'b1;
                    act_rsp_core = pend_q;
                    if ((pkind_q == RQ_IFETCH) ||
                        ((pkind_q == RQ_READ) && (cont_q || rival))) begin
                        act_rsp_kind = RS_DATA_SHARED;
                        shr_d        = NUM_CORES'(1) << pend_q;
                        st_d         = LN_SHARED;
                    end else begin
                        act_rsp_kind = RS_DATA_EXCL;
                        shr_d        = '0;
                        st_d         = LN_WAIT_UNBLK;
                    end
                end
            end
            LN_SHARED: begin
                if (ev_req) begin
                    act_rsp = 1'b1;
                    if (wants_excl(in_req_kind)) begin
                        act_inv      = |others;
                        act_inv_mask = others;
                        act_acks     = AW'(ones64(64'(others)));
                        act_rsp_kind = ((in_req_kind == RQ_UPGRADE) && (|(shr_q & req_bit)))
                                       ? RS_ACKS_ONLY : RS_DATA_EXCL;
                        shr_d  = '0;
                        pend_d = in_req_core;
                        st_d   = LN_WAIT_UNBLK;
                    end else begin
                        act_rsp_kind = RS_DATA_SHARED;
                        shr_d        = shr_q | req_bit;
                    end
                end
            end
            LN_HOME_EXCL: begin
                if (ev_req) begin
                    act_rsp = 1'b1;
                    if (in_req_kind == RQ_IFETCH) begin
                        act_rsp_kind = RS_DATA_SHARED;
                        shr_d        = req_bit;
                        st_d         = LN_SHARED;
                    end else begin
                        act_rsp_kind = RS_DATA_EXCL;
                        pend_d       = in_req_core;
                        st_d         = LN_WAIT_UNBLK;
                    end
                end
            end
            LN_PRIV_EXCL: begin
                if (ev_req) begin
                    act_fwd = 1'b1;
                    pend_d  = in_req_core;
                    if (wants_excl(in_req_kind)) begin
                        act_fwd_kind = FW_WRITE;
                        st_d         = LN_WAIT_UNBLK;
                    end else begin
                        act_fwd_kind = FW_READ;
                        st_d         = LN_WAIT_BOTH;
                    end
                end else if (wb_ok) begin
                    st_d = LN_HOME_EXCL;
                end
            end
            LN_WAIT_UNBLK: begin
                if (unblk_ok) begin
                    own_d = pend_q;
                    st_d  = LN_PRIV_EXCL;
                end
            end
            LN_WAIT_BOTH: begin
                if (unblk_ok)   st_d = LN_WAIT_WB;
                else if (wb_ok) st_d = LN_WAIT_UNBLK_S;
            end
            LN_WAIT_WB: begin
                if (wb_ok) begin
                    shr_d = pair_bits;
                    own_d = '0;
                    st_d  = LN_SHARED;
                end
            end
            LN_WAIT_UNBLK_S: begin
                if (unblk_ok) begin
                    shr_d = pair_bits;
                    own_d = '0;
                    st_d  = LN_SHARED;
                end
            end
            default: st_d = LN_ABSENT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LN_ABSENT;
            shr_q   <= '0;
            own_q   <= '0;
            pend_q  <= '0;
            pkind_q <= RQ_READ;
            cont_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            shr_q   <= shr_d;
            own_q   <= own_d;
            pend_q  <= pend_d;
            pkind_q <= pkind_d;
            cont_q  <= cont_d;
        end
    end

endmodule

// File: rtl/cdir_out_stage.sv
module cdir_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/coherence_dir.sv
module coherence_dir
    import cdir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [1:0]                     req_kind,
    input  logic [$clog2(NUM_CORES)-1:0]   req_core,
    input  logic [$clog2(NUM_LINES)-1:0]   req_line,
    input  logic                           msg_valid,
    input  logic                           msg_kind,
    input  logic [$clog2(NUM_CORES)-1:0]   msg_core,
    input  logic [$clog2(NUM_LINES)-1:0]   msg_line,
    output logic                           mem_req_valid,
    output logic [$clog2(NUM_LINES)-1:0]   mem_req_line,
    input  logic                           mem_resp_valid,
    input  logic [$clog2(NUM_LINES)-1:0]   mem_resp_line,
    output logic                           rsp_valid,
    output logic [1:0]                     rsp_kind,
    output logic [$clog2(NUM_CORES)-1:0]   rsp_core,
    output logic [$clog2(NUM_LINES)-1:0]   rsp_line,
    output logic [$clog2(NUM_CORES+1)-1:0] rsp_acks,
    output logic                           fwd_valid,
    output logic                           fwd_kind,
    output logic [$clog2(NUM_CORES)-1:0]   fwd_core,
    output logic [$clog2(NUM_CORES)-1:0]   fwd_requester,
    output logic [$clog2(NUM_LINES)-1:0]   fwd_line,
    output logic                           inv_valid,
    output logic [NUM_CORES-1:0]           inv_mask,
    output logic [$clog2(NUM_LINES)-1:0]   inv_line
);

    localparam int CW = $clog2(NUM_CORES);
    localparam int LW = $clog2(NUM_LINES);
    localparam int AW = $clog2(NUM_CORES + 1);
    localparam int OW = (1 + 2 + CW + LW + AW) + (1 + 1 + CW + CW + LW)
                      + (1 + NUM_CORES + LW) + (1 + LW);

    logic [NUM_LINES-1:0] ln_idle;
    logic                 a_rsp      [NUM_LINES];
    rsp_kind_e            a_rsp_kind [NUM_LINES];
    logic [CW-1:0]        a_rsp_core [NUM_LINES];
    logic [AW-1:0]        a_acks     [NUM_LINES];
    logic                 a_fwd      [NUM_LINES];
    fwd_kind_e            a_fwd_kind [NUM_LINES];
    logic [CW-1:0]        a_fwd_tgt  [NUM_LINES];
    logic                 a_inv      [NUM_LINES];
    logic [NUM_CORES-1:0] a_inv_mask [NUM_LINES];
    logic                 a_mem      [NUM_LINES];

    logic req_fire;

    // A request waits while its line is busy, while a memory return needs the
    // response slot, or while a message is updating the same line.
    assign req_ready = ln_idle[req_line] && !mem_resp_valid &&
                       !(msg_valid && (msg_line == req_line));
    assign req_fire  = req_valid && req_ready;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        cdir_line_fsm #(.NUM_CORES(NUM_CORES)) u_line (
            .clk          (clk),
            .rst          (rst),
            .ev_req       (req_fire && (req_line == LW'(g))),
            .ev_msg       (msg_valid && (msg_line == LW'(g))),
            .ev_mem       (mem_resp_valid && (mem_resp_line == LW'(g))),
            .snoop        (req_valid && (req_line == LW'(g))),
            .in_req_kind  (req_kind_e'(req_kind)),
            .in_req_core  (req_core),
            .in_msg_kind  (msg_kind_e'(msg_kind)),
            .in_msg_core  (msg_core),
            .is_idle      (ln_idle[g]),
            .act_rsp      (a_rsp[g]),
            .act_rsp_kind (a_rsp_kind[g]),
            .act_rsp_core (a_rsp_core[g]),
            .act_acks     (a_acks[g]),
            .act_fwd      (a_fwd[g]),
            .act_fwd_kind (a_fwd_kind[g]),
            .act_fwd_tgt  (a_fwd_tgt[g]),
            .act_inv      (a_inv[g]),
            .act_inv_mask (a_inv_mask[g]),
            .act_mem      (a_mem[g])
        );
    end

    logic                 m_rsp, m_fwd, m_inv, m_mem;
    logic [1:0]           m_rsp_kind;
    logic [CW-1:0]        m_rsp_core, m_fwd_tgt;
    logic [LW-1:0]        m_rsp_line, m_fwd_line, m_mem_line;
    logic [AW-1:0]        m_acks;
    logic                 m_fwd_kind;
    logic [NUM_CORES-1:0] m_inv_mask;

    // At most one line acts on each output class per cycle.
    always_comb begin
        m_rsp = 1'b0; m_rsp_kind = '0; m_rsp_core = '0; m_rsp_line = '0; m_acks = '0;
        m_fwd = 1'b0; m_fwd_kind = 1'b0; m_fwd_tgt = '0; m_fwd_line = '0;
        m_inv = 1'b0; m_inv_mask = '0;
        m_mem = 1'b0; m_mem_line = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (a_rsp[i]) begin
                m_rsp      = 1'b1;
                m_rsp_kind = a_rsp_kind[i];
                m_rsp_core = a_rsp_core[i];
                m_rsp_line = LW'(i);
                m_acks     = a_acks[i];
                m_inv      = a_inv[i];
                m_inv_mask = a_inv_mask[i];
            end
            if (a_fwd[i]) begin
                m_fwd      = 1'b1;
                m_fwd_kind = a_fwd_kind[i];
                m_fwd_tgt  = a_fwd_tgt[i];
                m_fwd_line = LW'(i);
            end
            if (a_mem[i]) begin
                m_mem      = 1'b1;
                m_mem_line = LW'(i);
            end
        end
    end

    logic [OW-1:0] out_d, out_q;

    assign out_d = {m_rsp, m_rsp_kind, m_rsp_core, m_rsp_line, m_acks,
                    m_fwd, m_fwd_kind, m_fwd_tgt, req_core, m_fwd_line,
                    m_inv, m_inv_mask, m_rsp_line,
                    m_mem, m_mem_line};

    cdir_out_stage #(.W(OW)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (out_d),
        .q   (out_q)
    );

    assign {rsp_valid, rsp_kind, rsp_core, rsp_line, rsp_acks,
            fwd_valid, fwd_kind, fwd_core, fwd_requester, fwd_line,
            inv_valid, inv_mask, inv_line,
            mem_req_valid, mem_req_line} = out_q;

endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
    parameter int NUM_CORES = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           req_valid,
    input logic                           req_ready,
    input logic                           mem_resp_valid,
    input logic                           rsp_valid,
    input logic [$clog2(NUM_CORES)-1:0]   rsp_core,
    input logic [$clog2(NUM_CORES+1)-1:0] rsp_acks,
    input logic                           fwd_valid,
    input logic                           inv_valid,
    input logic [NUM_CORES-1:0]           inv_mask,
    input logic                           mem_req_valid
);

    // R2: one accepted request leads to exactly one action next cycle
    p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            ($countones({rsp_valid, fwd_valid, mem_req_valid}) == 1));

    // R1: a fetch stands alone and follows an accepted request
    p_fetch_alone_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (!rsp_valid && !fwd_valid && $past(req_valid && req_ready)));

    // R6: acknowledgement count equals the number of invalidated cores
    p_acks_match_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_acks == $countones(inv_mask)));

    // R6: the requester is never invalidated and invalidations ride with a response
    p_no_self_inv_r6: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (rsp_valid && !inv_mask[rsp_core]));

    // R9: a forwarded request is not also served locally
    p_fwd_not_local_r9: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (!rsp_valid && !mem_req_valid));

    // R3: every response has a cause one cycle earlier
    p_rsp_cause_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past((req_valid && req_ready) || mem_resp_valid));

endmodule

bind coherence_dir cdir_checker #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_resp_valid (mem_resp_valid),
    .rsp_valid      (rsp_valid),
    .rsp_core       (rsp_core),
    .rsp_acks       (rsp_acks),
    .fwd_valid      (fwd_valid),
    .inv_valid      (inv_valid),
    .inv_mask       (inv_mask),
    .mem_req_valid  (mem_req_valid)
);

// File: tb/coherence_dir_tb.sv
module coherence_dir_tb;

    localparam int NC = 4;
    localparam int NL = 8;
    localparam int CW = $clog2(NC);
    localparam int LW = $clog2(NL);
    localparam int AW = $clog2(NC + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          req_valid, req_ready;
    logic [1:0]    req_kind;
    logic [CW-1:0] req_core;
    logic [LW-1:0] req_line;
    logic          msg_valid, msg_kind;
    logic [CW-1:0] msg_core;
    logic [LW-1:0] msg_line;
    logic          mem_req_valid;
    logic [LW-1:0] mem_req_line;
    logic          mem_resp_valid;
    logic [LW-1:0] mem_resp_line;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [CW-1:0] rsp_core;
    logic [LW-1:0] rsp_line;
    logic [AW-1:0] rsp_acks;
    logic          fwd_valid, fwd_kind;
    logic [CW-1:0] fwd_core, fwd_requester;
    logic [LW-1:0] fwd_line;
    logic          inv_valid;
    logic [NC-1:0] inv_mask;
    logic [LW-1:0] inv_line;

    coherence_dir #(.NUM_CORES(NC), .NUM_LINES(NL)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_core(req_core), .req_line(req_line),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_core(msg_core), .msg_line(msg_line),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_core(rsp_core),
        .rsp_line(rsp_line), .rsp_acks(rsp_acks),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_core(fwd_core),
        .fwd_requester(fwd_requester), .fwd_line(fwd_line),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_line(inv_line)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;
    logic seen_ready;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_kind = 0; req_core = 0; req_line = 0;
        msg_valid = 0; msg_kind = 0; msg_core = 0; msg_line = 0;
        mem_resp_valid = 0; mem_resp_line = 0;
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive a request for one cycle; outputs of its acceptance are visible on return.
    task automatic issue(input int k, input int c, input int l);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_core = CW'(c); req_line = LW'(l);
        #1 seen_ready = req_ready;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic held(input string tag, input int k, input int c, input int l);
        issue(k, c, l);
        chk({tag, " ready"}, int'(seen_ready), 0);
        chk({tag, " no action"}, int'(rsp_valid | fwd_valid | mem_req_valid), 0);
    endtask

    task automatic send_msg(input int k, input int c, input int l);
        @(negedge clk);
        msg_valid = 1'b1; msg_kind = 1'(k); msg_core = CW'(c); msg_line = LW'(l);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic mem_back(input int l);
        @(negedge clk);
        mem_resp_valid = 1'b1; mem_resp_line = LW'(l);
        @(negedge clk);
        mem_resp_valid = 1'b0;
    endtask

    function automatic int popc(input int v);
        int n;
        n = 0;
        for (int i = 0; i < NC; i++) n += (v >> i) & 1;
        return n;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        reset_dut();
        // R1: reset state
        chk("R1 reset rsp", int'(rsp_valid | fwd_valid | inv_valid | mem_req_valid), 0);
        chk("R1 reset ready", int'(req_ready), 1);

        // R2: a memory return holds the request channel
        @(negedge clk);
        mem_resp_valid = 1'b1; mem_resp_line = 3'd7;
        req_valid = 1'b1; req_kind = 2'd0; req_core = 0; req_line = 0;
        #1 chk("R2 ready low on mem return", int'(req_ready), 0);
        @(negedge clk);
        idle_inputs();
        chk("R2 held request no fetch", int'(mem_req_valid), 0);
        // R2: a message to the same line holds the request channel
        @(negedge clk);
        msg_valid = 1'b1; msg_kind = 1'b0; msg_core = 0; msg_line = 3'd0;
        req_valid = 1'b1; req_kind = 2'd0; req_core = 1; req_line = 0;
        #1 chk("R2 ready low on same-line message", int'(req_ready), 0);
        @(negedge clk);
        idle_inputs();

        // R1/R3/R8: uncontended read miss on line 1
        issue(0, 0, 1);
        chk("R1 fetch", int'(mem_req_valid), 1);
        chk("R1 fetch line", int'(mem_req_line), 1);
        chk("R1 no rsp with fetch", int'(rsp_valid), 0);
        mem_back(1);
        chk("R3 rsp valid", int'(rsp_valid), 1);
        chk("R3 read miss excl", int'(rsp_kind), 1);
        chk("R3 rsp core", int'(rsp_core), 0);
        chk("R3 acks", int'(rsp_acks), 0);
        held("R8 blocked", 0, 2, 1);
        send_msg(0, 3, 1);                       // R12: wrong core
        held("R12 wrong unblock ignored", 0, 2, 1);
        send_msg(0, 0, 1);
        // R9: read forwarded to owner 0
        issue(0, 2, 1);
        chk("R9 fwd", int'(fwd_valid), 1);
        chk("R9 fwd kind", int'(fwd_kind), 0);
        chk("R9 fwd owner", int'(fwd_core), 0);
        chk("R9 fwd requester", int'(fwd_requester), 2);
        chk("R9 fwd line", int'(fwd_line), 1);
        chk("R9 no local rsp", int'(rsp_valid), 0);
        // R10: unblock first, then writeback
        send_msg(0, 2, 1);
        held("R10 waits writeback", 0, 3, 1);
        send_msg(1, 3, 1);                       // R12: writeback from non-owner
        held("R12 wrong writeback ignored", 0, 3, 1);
        send_msg(1, 0, 1);
        issue(2, 3, 1);
        chk("R10 sharers after read", int'(inv_mask), 5);
        chk("R10 acks", int'(rsp_acks), 2);
        chk("R6 write kind", int'(rsp_kind), 1);

        // R10: writeback first, then unblock on line 2
        issue(2, 1, 2);
        chk("R3 write miss fetch", int'(mem_req_valid), 1);
        mem_back(2);
        chk("R3 write miss excl", int'(rsp_kind), 1);
        send_msg(0, 1, 2);
        issue(0, 3, 2);
        chk("R9 fwd owner line2", int'(fwd_core), 1);
        send_msg(1, 1, 2);
        held("R10 waits unblock", 0, 0, 2);
        send_msg(0, 3, 2);
        issue(3, 3, 2);
        chk("R6 upgrade ack-only", int'(rsp_kind), 2);
        chk("R10 other sharer", int'(inv_mask), 2);
        chk("R6 upgrade acks", int'(rsp_acks), 1);

        // R4: contended read miss on line 3
        issue(0, 1, 3);
        held("R4 held during fetch", 0, 2, 3);
        mem_back(3);
        chk("R4 contended shared", int'(rsp_kind), 0);
        chk("R4 rsp core", int'(rsp_core), 1);
        issue(0, 2, 3);
        chk("R5 retried read shared", int'(rsp_kind), 0);
        chk("R5 retried core", int'(rsp_core), 2);
        // R4: instruction fetch miss on line 4
        issue(1, 0, 4);
        mem_back(4);
        chk("R4 ifetch shared", int'(rsp_kind), 0);

        // R11/R7: home-exclusive line 5
        issue(2, 2, 5);
        mem_back(5);
        send_msg(0, 2, 5);
        send_msg(1, 2, 5);
        issue(0, 0, 5);
        chk("R7 read served", int'(rsp_valid), 1);
        chk("R7 read excl", int'(rsp_kind), 1);
        chk("R7 no fwd", int'(fwd_valid | mem_req_valid), 0);
        send_msg(0, 0, 5);
        send_msg(1, 0, 5);
        issue(1, 1, 5);
        chk("R7 ifetch shared", int'(rsp_kind), 0);
        issue(2, 3, 5);
        chk("R5 sharer recorded", int'(inv_mask), 2);

        // R9: write forward on line 6
        issue(2, 0, 6);
        mem_back(6);
        send_msg(0, 0, 6);
        issue(2, 1, 6);
        chk("R9 write fwd", int'(fwd_valid), 1);
        chk("R9 write fwd kind", int'(fwd_kind), 1);
        chk("R9 write fwd owner", int'(fwd_core), 0);
        held("R8 blocked after fwd write", 0, 2, 6);
        send_msg(0, 1, 6);
        issue(0, 2, 6);
        chk("R9 new owner", int'(fwd_core), 1);

        // R12: writeback to absent line 7 has no effect
        send_msg(1, 0, 7);
        issue(0, 0, 7);
        chk("R12 absent stays absent", int'(mem_req_valid), 1);

        // R5/R6/R8 sweep over sharer sets and writers
        for (int m = 1; m < (1 << NC); m++) begin
            for (int w = 0; w < NC; w++) begin
                int l;
                int first;
                int expm;
                reset_dut();
                l = (m + w) % NL;
                first = -1;
                for (int c = NC - 1; c >= 0; c--) if ((m >> c) & 1) first = c;
                issue(1, first, l);
                mem_back(l);
                chk("R4 sweep first sharer", int'(rsp_core), first);
                for (int c = first + 1; c < NC; c++) begin
                    if ((m >> c) & 1) begin
                        issue(0, c, l);
                        chk("R5 sweep shared add", int'(rsp_kind), 0);
                    end
                end
                expm = m & ~(1 << w);
                issue(((m >> w) & 1) ? 3 : 2, w, l);
                chk("R6 sweep kind", int'(rsp_kind), ((m >> w) & 1) ? 2 : 1);
                chk("R6 sweep mask", int'(inv_mask), expm);
                chk("R6 sweep acks", int'(rsp_acks), popc(expm));
                chk("R6 sweep inv valid", int'(inv_valid), int'(expm != 0));
                held("R8 sweep blocked", 0, (w + 1) % NC, l);
                send_msg(0, w, l);
                issue(0, (w + 1) % NC, l);
                chk("R8 sweep owner", int'(fwd_core), w);
            end
        end

        finish_run();
    end

endmodule